// File: doc/BRIEF.md
# IDE PIO Host Timing Controller

This block drives the host side of a parallel ATA disk interface in programmed I/O mode. A command names a register (two chip-select lines plus a 3-bit register address), a direction, a timing mode and a word count. The controller then runs one or more strobed bus cycles. Each cycle has an address setup phase, a strobe phase that a slow drive can stretch with its ready line, and a recovery phase. The total cycle length is a whole number of 48 MHz clocks that the mode selects.

Single accesses move one word between the command port and the drive. Block accesses move a run of words between the drive and a word-wide local memory port. The words go one per bus cycle, with no gap between cycles, starting at a given memory address. A hung drive is caught by a programmable ready-wait limit.

Top module: `ide_pio_ctrl`

## Requirements
- R1: While reset is held, both chip selects and both strobes are high (inactive), the data output enable is low, and busy, done and timeout are low.
- R2: With ready high, every bus cycle lasts 30, 20, 13, 10 or 8 clocks for modes 0, 1, 2, 3 and 4. Mode codes 5 to 7 behave as mode 4. The selected chip select lines stay low for exactly those clocks.
- R3: In every cycle, chip select and register address are valid for exactly 2 clocks before the strobe falls. With ready high, the strobe is low for 16, 11, 7, 6 or 4 clocks for modes 0 to 4. Only the strobe of the command's direction moves. During a cycle, `ide_cs_n[i]` is low exactly when `cmd_cs[i]` was 1, and `ide_addr` equals `cmd_reg`.
- R4: Ready is sampled at the last nominal strobe clock and after it. Each clock that ready stays low there adds one clock to the strobe and to the cycle.
- R5: If ready stays low for more than `cmd_limit` extra clocks, the strobe ends after exactly `cmd_limit` extra clocks and `timeout` goes high. No further words of the command run. `timeout` stays high until the next command is accepted, which clears it.
- R6: A read captures the bus data at the clock edge that releases the read strobe. `rd_data` holds it afterwards.
- R7: In a write cycle, the output enable is high from the first setup clock until one clock after the write strobe rises. The driven data is the command word for single writes. The enable is low at every other time and in read cycles.
- R8: A block write of N words drives word i of the burst from memory address `cmd_base`+i (8-bit wraparound).
- R9: A block read of N words stores the data of bus cycle i at memory address `cmd_base`+i.
- R10: Cycles of a block follow each other with no idle clock: chip select stays low and strobes fall exactly one cycle length apart.
- R11: `done` is high for exactly one clock, in the first clock after the last cycle ends, and `busy` is low in that clock. A block command with count 0 gives `done` in the clock after acceptance, with no bus activity.
- R12: A command is accepted only when `busy` is low. A command presented while busy is ignored. The mode and all other fields are taken at acceptance, so a mode change only affects later commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when busy is low |
| cmd_mode | input | 3 | Timing mode 0..4 (5..7 act as 4) |
| cmd_write | input | 1 | 1 = write to drive, 0 = read from drive |
| cmd_block | input | 1 | 1 = burst through local memory, 0 = single word |
| cmd_cs | input | 2 | Chip select lines to assert, bit i drives line i |
| cmd_reg | input | 3 | Drive register address |
| cmd_count | input | 16 | Word count of a block command |
| cmd_base | input | 8 | First local memory address of a block |
| cmd_wdata | input | 16 | Data of a single write |
| cmd_limit | input | 8 | Extra clocks ready may stay low before timeout |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-clock completion pulse |
| timeout | output | 1 | Ready wait limit was exceeded |
| rd_data | output | 16 | Last word read from the drive |
| mem_addr | output | 8 | Local memory address |
| mem_we | output | 1 | Local memory write enable |
| mem_wdata | output | 16 | Local memory write data |
| mem_rdata | input | 16 | Local memory read data (combinational) |
| ide_cs_n | output | 2 | Chip selects, active low |
| ide_addr | output | 3 | Register address |
| ide_rd_n | output | 1 | Read strobe, active low |
| ide_wr_n | output | 1 | Write strobe, active low |
| ide_iordy | input | 1 | Drive ready |
| ide_d_o | output | 16 | Data bus out |
| ide_d_oe | output | 1 | Data bus output enable |
| ide_d_i | input | 16 | Data bus in |

## Verification
Two decisions can fall in the same cycle. One is ending a strobe because the ready wait ran out. The other is the burst sequencer deciding to chain the next word. The bench provokes this by holding ready low through a three-word block read with a small limit. It accepts the run only if exactly one strobe of length nominal plus limit appears, the timeout flag is set, and `done` comes once with no later chip-select activity. The second collision is a new command arriving while a burst runs its cycles. It is provoked mid-burst with a different mode and direction, and judged by unchanged cycle counts and a bus that stays quiet after `done`.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

  // clocks between chip select/address valid and the strobe edge
  localparam int SETUP_CLKS = 2;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_ACT   = 2'd2,
    PH_REC   = 2'd3
  } phase_e;

  function automatic logic [2:0] mode_clamp(input logic [2:0] m);
    return (m > 3'd4) ? 3'd4 : m;
  endfunction

  // whole bus cycle, in system clocks
  function automatic int unsigned total_clks(input logic [2:0] m);
    case (mode_clamp(m))
      3'd0:    return 30;
      3'd1:    return 20;
      3'd2:    return 13;
      3'd3:    return 10;
      default: return 8;
    endcase
  endfunction

  // nominal strobe-low length, in system clocks
  function automatic int unsigned act_clks(input logic [2:0] m);
    case (mode_clamp(m))
      3'd0:    return 16;
      3'd1:    return 11;
      3'd2:    return 7;
      3'd3:    return 6;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/ide_pio_rst_sync.sv
module ide_pio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/ide_pio_timing.sv
module ide_pio_timing
  import ide_pio_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic [2:0]    mode,
  output logic [TW-1:0] act_len,
  output logic [TW-1:0] rec_len
);
  assign act_len = TW'(act_clks(mode));
  assign rec_len = TW'(total_clks(mode) - act_clks(mode) - SETUP_CLKS);
endmodule

// File: rtl/ide_pio_cycle.sv
module ide_pio_cycle
  import ide_pio_pkg::*;
#(
  parameter int DW   = 16,
  parameter int TW   = 8,
  parameter int LIMW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            wr_in,
  input  logic [DW-1:0]   din,
  input  logic [TW-1:0]   act_len,
  input  logic [TW-1:0]   rec_len,
  input  logic [LIMW-1:0] lim,
  input  logic            iordy,
  input  logic [DW-1:0]   bus_din,
  output logic            in_cycle,
  output logic            rd_n,
  output logic            wr_n,
  output logic            oe,
  output logic [DW-1:0]   dout,
  output logic [DW-1:0]   rdata,
  output logic            rec_first,
  output logic            cyc_end,
  output logic            to_hit
);
  phase_e          ph_q, ph_d;
  logic [TW-1:0]   cnt_q, cnt_d;
  logic [LIMW-1:0] wcnt_q, wcnt_d;
  logic            wr_q, wr_d;
  logic [DW-1:0]   dout_q, dout_d;
  logic [DW-1:0]   rdata_q, rdata_d;
  logic            load, cap;

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    wcnt_d  = wcnt_q;
    wr_d    = wr_q;
    dout_d  = dout_q;
    rdata_d = rdata_q;
    load    = 1'b0;
    cap     = 1'b0;
    to_hit  = 1'b0;
    case (ph_q)
      PH_IDLE: load = start;
      PH_SETUP: begin
        if (cnt_q == '0) begin
          ph_d   = PH_ACT;
          cnt_d  = act_len - TW'(1);
          wcnt_d = '0;
        end else begin
          cnt_d = cnt_q - TW'(1);
        end
      end
      PH_ACT: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - TW'(1);
        end else if (iordy || (wcnt_q == lim)) begin
          ph_d   = PH_REC;
          cnt_d  = rec_len - TW'(1);
          cap    = 1'b1;
          to_hit = !iordy;
        end else begin
          wcnt_d = wcnt_q + LIMW'(1);
        end
      end
      PH_REC: begin
        if (cnt_q == '0) begin
          if (start) load = 1'b1;
          else       ph_d = PH_IDLE;
        end else begin
          cnt_d = cnt_q - TW'(1);
        end
      end
      default: ph_d = PH_IDLE;
    endcase
    if (load) begin
      ph_d   = PH_SETUP;
      cnt_d  = TW'(SETUP_CLKS - 1);
      wr_d   = wr_in;
      dout_d = din;
    end
    if (cap && !wr_q) rdata_d = bus_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      wcnt_q  <= '0;
      wr_q    <= 1'b0;
      dout_q  <= '0;
      rdata_q <= '0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      wcnt_q  <= wcnt_d;
      wr_q    <= wr_d;
      dout_q  <= dout_d;
      rdata_q <= rdata_d;
    end
  end

  assign in_cycle  = (ph_q != PH_IDLE);
  assign rec_first = (ph_q == PH_REC) && (cnt_q == rec_len - TW'(1));
  assign cyc_end   = (ph_q == PH_REC) && (cnt_q == '0);
  assign rd_n      = !((ph_q == PH_ACT) && !wr_q);
  assign wr_n      = !((ph_q == PH_ACT) && wr_q);
  assign oe        = wr_q && ((ph_q == PH_SETUP) || (ph_q == PH_ACT) || rec_first);
  assign dout      = dout_q;
  assign rdata     = rdata_q;

  // stretch counter never runs past the latched limit
  assert_wait_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ACT) |-> (wcnt_q <= lim));

  // a strobe is only entered from the setup phase
  assert_act_from_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_ACT) && ($past(ph_q) != PH_ACT)) |-> ($past(ph_q) == PH_SETUP));
endmodule

// File: rtl/ide_pio_ctrl.sv
module ide_pio_ctrl
  import ide_pio_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 8,
  parameter int CNTW = 16,
  parameter int LIMW = 8,
  parameter int NCS  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_mode,
  input  logic            cmd_write,
  input  logic            cmd_block,
  input  logic [NCS-1:0]  cmd_cs,
  input  logic [2:0]      cmd_reg,
  input  logic [CNTW-1:0] cmd_count,
  input  logic [AW-1:0]   cmd_base,
  input  logic [DW-1:0]   cmd_wdata,
  input  logic [LIMW-1:0] cmd_limit,
  output logic            busy,
  output logic            done,
  output logic            timeout,
  output logic [DW-1:0]   rd_data,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_we,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic [NCS-1:0]  ide_cs_n,
  output logic [2:0]      ide_addr,
  output logic            ide_rd_n,
  output logic            ide_wr_n,
  input  logic            ide_iordy,
  output logic [DW-1:0]   ide_d_o,
  output logic            ide_d_oe,
  input  logic [DW-1:0]   ide_d_i
);
  localparam int TW = 8;

  logic            rs_n;
  logic            acc;
  // command fields, loaded with clock enable acc
  logic [2:0]      mode_q;
  logic            wr_q, blk_q;
  logic [NCS-1:0]  cs_q;
  logic [2:0]      reg_q;
  logic [DW-1:0]   wdata_q;
  logic [LIMW-1:0] lim_q;
  // sequencing state
  logic            busy_q, busy_d;
  logic            done_q, done_d;
  logic            kick_q, kick_d;
  logic            abort_q, abort_d;
  logic            to_q, to_d;
  logic [CNTW-1:0] left_q, left_d;
  logic [AW-1:0]   ptr_q, ptr_d;
  // engine links
  logic [TW-1:0]   act_len, rec_len;
  logic            start, last_word;
  logic            in_cycle, rec_first, cyc_end, to_hit;
  logic [DW-1:0]   eng_din, eng_rdata;

  ide_pio_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(rs_n));

  ide_pio_timing #(.TW(TW)) u_tim (
    .mode(mode_q), .act_len(act_len), .rec_len(rec_len)
  );

  assign acc       = cmd_valid && !busy_q;
  assign last_word = (left_q == CNTW'(1)) || abort_q;
  assign start     = kick_q || (cyc_end && busy_q && !last_word);
  assign eng_din   = blk_q ? mem_rdata : wdata_q;

  ide_pio_cycle #(.DW(DW), .TW(TW), .LIMW(LIMW)) u_cyc (
    .clk(clk), .rst_n(rs_n), .start(start), .wr_in(wr_q), .din(eng_din),
    .act_len(act_len), .rec_len(rec_len), .lim(lim_q), .iordy(ide_iordy),
    .bus_din(ide_d_i), .in_cycle(in_cycle), .rd_n(ide_rd_n), .wr_n(ide_wr_n),
    .oe(ide_d_oe), .dout(ide_d_o), .rdata(eng_rdata), .rec_first(rec_first),
    .cyc_end(cyc_end), .to_hit(to_hit)
  );

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      mode_q  <= '0;
      wr_q    <= 1'b0;
      blk_q   <= 1'b0;
      cs_q    <= '0;
      reg_q   <= '0;
      wdata_q <= '0;
      lim_q   <= '0;
    end else if (acc) begin
      mode_q  <= cmd_mode;
      wr_q    <= cmd_write;
      blk_q   <= cmd_block;
      cs_q    <= cmd_cs;
      reg_q   <= cmd_reg;
      wdata_q <= cmd_wdata;
      lim_q   <= cmd_limit;
    end
  end

  always_comb begin
    busy_d  = busy_q;
    done_d  = 1'b0;
    kick_d  = 1'b0;
    abort_d = abort_q;
    to_d    = to_q;
    left_d  = left_q;
    ptr_d   = ptr_q;
    if (acc) begin
      to_d    = 1'b0;
      abort_d = 1'b0;
      ptr_d   = cmd_base;
      left_d  = cmd_block ? cmd_count : CNTW'(1);
      if (cmd_block && (cmd_count == '0)) begin
        done_d = 1'b1;
      end else begin
        busy_d = 1'b1;
        kick_d = 1'b1;
      end
    end
    if (to_hit) begin
      to_d    = 1'b1;
      abort_d = 1'b1;
    end
    if (rec_first) ptr_d = ptr_q + AW'(1);
    if (cyc_end) begin
      left_d = left_q - CNTW'(1);
      if (last_word) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      kick_q  <= 1'b0;
      abort_q <= 1'b0;
      to_q    <= 1'b0;
      left_q  <= '0;
      ptr_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      kick_q  <= kick_d;
      abort_q <= abort_d;
      to_q    <= to_d;
      left_q  <= left_d;
      ptr_q   <= ptr_d;
    end
  end

  for (genvar gi = 0; gi < NCS; gi++) begin : g_cs
    assign ide_cs_n[gi] = !(in_cycle && cs_q[gi]);
  end

  assign ide_addr  = reg_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign timeout   = to_q;
  assign rd_data   = eng_rdata;
  assign mem_addr  = ptr_q;
  assign mem_we    = blk_q && !wr_q && rec_first;
  assign mem_wdata = eng_rdata;

  // strobe edge must follow a clock with a chip select already low
  assert_cs_before_strobe_R3: assert property (@(posedge clk) disable iff (!rs_n)
    ($fell(ide_rd_n) || $fell(ide_wr_n)) |-> ($past(ide_cs_n) != {NCS{1'b1}}));

  // bus is never driven while the drive is told to drive it
  assert_oe_not_read_R7: assert property (@(posedge clk) disable iff (!rs_n)
    ide_d_oe |-> ide_rd_n);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rs_n)
    done |-> (!busy && (ide_cs_n == {NCS{1'b1}})));

  // a request while busy leaves the latched mode alone
  assert_ignore_busy_R12: assert property (@(posedge clk) disable iff (!rs_n)
    (busy && cmd_valid) |=> $stable(mode_q));

  // no bus cycle outside a command
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rs_n)
    (!busy_q && !kick_q) |-> (ide_rd_n && ide_wr_n && !ide_d_oe));
endmodule

// File: tb/tb_ide_pio_ctrl.sv
module tb_ide_pio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_write, cmd_block;
  logic [2:0]  cmd_mode, cmd_reg;
  logic [1:0]  cmd_cs;
  logic [15:0] cmd_count, cmd_wdata;
  logic [7:0]  cmd_base, cmd_limit;
  logic        busy, done, timeout;
  logic [15:0] rd_data;
  logic [7:0]  mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata, mem_rdata;
  logic [1:0]  ide_cs_n;
  logic [2:0]  ide_addr;
  logic        ide_rd_n, ide_wr_n, ide_iordy, ide_d_oe;
  logic [15:0] ide_d_o, ide_d_i;

  logic [15:0] wmem [0:255];
  logic [15:0] rmem [0:255];
  int n_chk = 0;
  int n_fail = 0;

  always #10ns clk = ~clk;

  ide_pio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .cmd_write(cmd_write), .cmd_block(cmd_block), .cmd_cs(cmd_cs),
    .cmd_reg(cmd_reg), .cmd_count(cmd_count), .cmd_base(cmd_base),
    .cmd_wdata(cmd_wdata), .cmd_limit(cmd_limit), .busy(busy), .done(done),
    .timeout(timeout), .rd_data(rd_data), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ide_cs_n(ide_cs_n),
    .ide_addr(ide_addr), .ide_rd_n(ide_rd_n), .ide_wr_n(ide_wr_n),
    .ide_iordy(ide_iordy), .ide_d_o(ide_d_o), .ide_d_oe(ide_d_oe),
    .ide_d_i(ide_d_i)
  );

  assign mem_rdata = wmem[mem_addr];
  always @(posedge clk) if (mem_we) rmem[mem_addr] <= mem_wdata;

  function automatic int tot_exp(input logic [2:0] m);
    case (m)
      3'd0: return 30;
      3'd1: return 20;
      3'd2: return 13;
      3'd3: return 10;
      default: return 8;
    endcase
  endfunction

  function automatic int act_exp(input logic [2:0] m);
    case (m)
      3'd0: return 16;
      3'd1: return 11;
      3'd2: return 7;
      3'd3: return 6;
      default: return 4;
    endcase
  endfunction

  function automatic logic [15:0] pat(input logic [15:0] s, input int i);
    return s ^ 16'(i * 4951 + 7);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] m, input bit w, input bit b, input int cnt,
                     input logic [7:0] base, input int stall, input int lim,
                     input bit inj, input logic [1:0] cs, input logic [2:0] rg);
    int a, t, eff, words, wex, pre, wcur, nstr, per, cs_cnt, oe_cnt, dcnt, bad, dbad;
    int busy_first, after;
    bit toe, st, ost, csl, prev_st, first_fall;
    logic [15:0] seed, wd, expw;
    a = act_exp(m); t = tot_exp(m);
    seed = 16'($urandom); wd = 16'($urandom);
    eff = (stall < lim) ? stall : lim;
    toe = (stall > lim);
    words = b ? cnt : 1;
    wex = (toe && words > 0) ? 1 : words;
    pre = 0; wcur = 0; nstr = 0; per = 0; cs_cnt = 0; oe_cnt = 0; dcnt = 0;
    bad = 0; dbad = 0; after = 0; prev_st = 0; first_fall = 0; busy_first = 0;
    @(negedge clk);
    cmd_mode = m; cmd_write = w; cmd_block = b; cmd_count = 16'(cnt);
    cmd_base = base; cmd_wdata = wd; cmd_limit = 8'(lim); cmd_cs = cs; cmd_reg = rg;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int c = 0; c < 4000; c++) begin
      if (c > 0) @(negedge clk);
      if (c == 0) busy_first = int'(busy);
      per++;
      st  = w ? !ide_wr_n : !ide_rd_n;
      ost = w ? !ide_rd_n : !ide_wr_n;
      csl = (ide_cs_n != 2'b11);
      if (ost) bad++;
      if (csl) begin
        cs_cnt++;
        if (ide_cs_n != ~cs || ide_addr != rg) bad++;
        if (!first_fall && !st) pre++;
      end
      if (ide_d_oe) oe_cnt++;
      if (st) begin
        if (!prev_st) begin
          if (first_fall) chk("R10", "strobe fall spacing", per, t + eff);
          first_fall = 1; per = 0;
        end
        wcur++;
        expw = b ? wmem[8'(base + 8'(nstr))] : wd;
        if (w && (!ide_d_oe || ide_d_o != expw)) dbad++;
      end else if (prev_st) begin
        chk(stall > 0 ? "R4" : "R3", "strobe width", wcur, a + eff);
        nstr++; wcur = 0;
      end
      ide_iordy = st ? (wcur >= a + stall) : 1'b1;
      ide_d_i = pat(seed, nstr);
      if (done) begin dcnt++; if (busy) bad++; end
      if (dcnt > 0 && csl) bad++;
      if (inj && c == 6) begin
        cmd_mode = m ^ 3'd1; cmd_write = !w; cmd_count = 16'd9; cmd_valid = 1'b1;
      end else if (inj && c == 7) cmd_valid = 1'b0;
      if (dcnt > 0) after++;
      if (after >= (inj ? 40 : 4)) break;
      prev_st = st;
    end
    chk("R11", "busy after accept", busy_first, (wex > 0) ? 1 : 0);
    chk("R11", "done pulses", dcnt, 1);
    chk("R2", "chip select low clocks", cs_cnt, wex * (t + eff));
    chk("R3", "setup clocks", pre, (wex > 0) ? 2 : 0);
    chk("R3", "protocol violations", bad, 0);
    chk(toe ? "R5" : "R10", "strobes", nstr, wex);
    chk("R5", "timeout flag", int'(timeout), int'(toe));
    chk("R7", "output enable clocks", oe_cnt, w ? wex * (a + eff + 3) : 0);
    if (w) chk(b ? "R8" : "R7", "write data mismatches", dbad, 0);
    if (!w && wex > 0) chk("R6", "read capture", int'(rd_data), int'(pat(seed, wex - 1)));
    if (!w && b)
      for (int i = 0; i < wex; i++)
        chk("R9", "memory word", int'(rmem[8'(base + 8'(i))]), int'(pat(seed, i)));
    if (inj) chk("R12", "strobes with ignored request", nstr, wex);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd41));
    for (int i = 0; i < 256; i++) wmem[i] = 16'($urandom);
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_mode = '0; cmd_write = 1'b0; cmd_block = 1'b0;
    cmd_cs = 2'b01; cmd_reg = '0; cmd_count = '0; cmd_base = '0; cmd_wdata = '0;
    cmd_limit = '0; ide_iordy = 1'b1; ide_d_i = '0;
    repeat (3) @(negedge clk);
    chk("R1", "chip selects in reset", int'(ide_cs_n), 3);
    chk("R1", "strobes in reset", int'({ide_rd_n, ide_wr_n}), 3);
    chk("R1", "enable/busy/done/timeout in reset", int'({ide_d_oe, busy, done, timeout}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // directed corners
    run(3'd0, 0, 0, 1, 8'd0,   0, 20, 0, 2'b01, 3'd7);
    run(3'd4, 1, 0, 1, 8'd0,   0, 20, 0, 2'b10, 3'd0);
    run(3'd7, 0, 0, 1, 8'd0,   0, 20, 0, 2'b11, 3'd2);
    run(3'd2, 1, 1, 4, 8'd254, 0, 20, 0, 2'b01, 3'd0);
    run(3'd3, 0, 1, 5, 8'd10,  2, 20, 0, 2'b01, 3'd0);
    run(3'd1, 0, 1, 3, 8'd40,  50, 5, 0, 2'b01, 3'd0);
    run(3'd1, 1, 0, 1, 8'd0,   0, 5,  0, 2'b01, 3'd1);
    run(3'd2, 0, 1, 0, 8'd60,  0, 5,  0, 2'b01, 3'd0);
    run(3'd0, 1, 1, 2, 8'd80,  0, 5,  1, 2'b01, 3'd0);
    run(3'd4, 0, 0, 1, 8'd0,   4, 4,  0, 2'b10, 3'd3);
    // random mix
    for (int k = 0; k < 14; k++) begin
      bit rb;
      rb = 1'($urandom);
      run(3'($urandom % 8), 1'($urandom), rb, rb ? 1 + int'($urandom % 4) : 1,
          8'($urandom), int'($urandom % 4), 3 + int'($urandom % 4), 0,
          2'(1 + $urandom % 3), 3'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule